// File: doc/BRIEF.md
# Pulse-Driven Setpoint Counter Controller

This block turns two slow, asynchronous logic lines into a setpoint code and a run flag for a switch-mode bias converter. One line (the step line) supplies pulses; the other (the mode line) selects what those pulses mean. With the mode line high, each rising edge of the step line advances a setpoint counter by one. With the mode line low, a high step line returns the counter to mid-scale while the converter stays running. With both lines low, the converter is shut down and the counter keeps its value.

The counter wraps from its top code to zero, so a host that can only count upward can still lower the setpoint: a full lap less one step moves the setpoint down by one. Both lines cross into the system clock domain through multi-flop synchronizers before any decision is made. The code output feeds a current-output DAC whose 64 equal steps span roughly one third to full scale of its current range. The DAC and power stage are outside this block.

Top module: `setpt_ctrl`

## Requirements
- R1: While the active-high asynchronous reset `rst` is asserted, `code` equals mid-scale (binary 100000 for the default 6-bit width, i.e. 32) and `run_en` is 1.
- R2: With `mode_in` high, each rising edge of `step_in` raises `code` by exactly one; holding `step_in` high adds nothing further.
- R3: With `mode_in` low and `step_in` high, `code` returns to 32 and `run_en` is 1.
- R4: With both `mode_in` and `step_in` low, `run_en` is 0 and `code` keeps the value it had.
- R5: While `step_in` stays low, `code` does not change, however `mode_in` toggles.
- R6: A step from code 63 gives code 0, so 63 steps from any code give that code minus one (modulo 64).
- R7: While `mode_in` is high, `run_en` is 1.
- R8: With the default two synchronizer stages, a change on the input pins appears at the outputs on the third rising clock edge after it, and not before.
- R9: A rising edge of `step_in` that arrives together with `mode_in` falling counts as a mid-scale reload, not a step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Asynchronous active-high power-on reset |
| step_in | input | 1 | Asynchronous step/reload line |
| mode_in | input | 1 | Asynchronous mode line (high: count, low: reload or shut down) |
| code | output | CODE_W | Setpoint code for the current-output DAC |
| run_en | output | 1 | Converter enable, low during shutdown |

## Verification
The hardest case to reach from the pins is the coincidence of R9: a step edge and a mode fall must land in the same synchronized cycle, which the bench produces by changing both pins on the same falling clock edge so both synchronizers carry them through together. The wrap of R6 needs the counter driven through a full lap, done with a directed run of 63 pulses from mid-scale, followed by seeded random pairs of pin levels whose expected code and enable come from a truth-table model.

// File: rtl/setpt_pkg.sv
package setpt_pkg;

   // Counter action decoded from the synchronized lines.
   typedef enum logic [1:0] {
      ACT_HOLD = 2'd0,
      ACT_STEP = 2'd1,
      ACT_MID  = 2'd2
   } setpt_act_e;

   // Code one half of the way up a counter of the given width.
   function automatic int unsigned mid_of(input int unsigned width);
      return 1 << (width - 1);
   endfunction

endpackage

// File: rtl/setpt_sync.sv
module setpt_sync #(
   parameter int unsigned WIDTH  = 2,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [WIDTH-1:0] d_async,
   output logic [WIDTH-1:0] q_sync
);

   if (STAGES < 2) begin : g_bad_stages
      $error("setpt_sync: STAGES must be at least 2");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= d_async;
         end
      end else begin : g_next
         always_ff @(posedge clk or posedge rst) begin
            if (rst) chain[s] <= RST_VAL;
            else     chain[s] <= chain[s-1];
         end
      end
   end

   assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/setpt_decode.sv
module setpt_decode
   import setpt_pkg::*;
(
   input  logic       clk,
   input  logic       rst,
   input  logic       mode_s,
   input  logic       step_s,
   output setpt_act_e act,
   output logic       run_q
);

   logic step_prev;
   logic step_rise;

   always_ff @(posedge clk or posedge rst) begin
      if (rst) step_prev <= 1'b0;
      else     step_prev <= step_s;
   end

   assign step_rise = step_s & ~step_prev;

   // Mode low with step high wins over any edge (reload before step).
   always_comb begin
      act = ACT_HOLD;
      if (!mode_s) begin
         if (step_s) act = ACT_MID;
      end else if (step_rise) begin
         act = ACT_STEP;
      end
   end

   // Running unless both lines are low; reset leaves the block running.
   always_ff @(posedge clk or posedge rst) begin
      if (rst) run_q <= 1'b1;
      else     run_q <= mode_s | step_s;
   end

   // R2: a held step line yields no second step
   assert_single_step_R2: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_STEP) |=> (act != ACT_STEP));

endmodule

// File: rtl/setpt_counter.sv
module setpt_counter
   import setpt_pkg::*;
#(
   parameter int unsigned CODE_W = 6
) (
   input  logic              clk,
   input  logic              rst,
   input  setpt_act_e        act,
   output logic [CODE_W-1:0] code_q
);

   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(mid_of(CODE_W));
   localparam logic [CODE_W-1:0] ONE      = CODE_W'(1);

   logic [CODE_W-1:0] code_d;

   always_comb begin
      unique case (act)
         ACT_STEP: code_d = code_q + ONE;
         ACT_MID:  code_d = MID_CODE;
         default:  code_d = code_q;
      endcase
   end

   always_ff @(posedge clk or posedge rst) begin
      if (rst) code_q <= MID_CODE;
      else     code_q <= code_d;
   end

   assert_step_plus_one_R2: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_STEP) |=> (code_q == CODE_W'($past(code_q) + 1)));

   assert_wrap_to_zero_R6: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_STEP && (&code_q)) |=> (code_q == '0));

   assert_hold_keeps_R4: assert property (@(posedge clk) disable iff (rst)
      (act == ACT_HOLD) |=> $stable(code_q));

endmodule

// File: rtl/setpt_ctrl.sv
module setpt_ctrl
   import setpt_pkg::*;
#(
   parameter int unsigned CODE_W      = 6,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              step_in,
   input  logic              mode_in,
   output logic [CODE_W-1:0] code,
   output logic              run_en
);

   localparam logic [CODE_W-1:0] MID_CODE = CODE_W'(mid_of(CODE_W));

   if (CODE_W < 2 || CODE_W > 16) begin : g_bad_width
      $error("setpt_ctrl: CODE_W must lie in 2..16");
   end
   if (SYNC_STAGES < 2 || SYNC_STAGES > 4) begin : g_bad_sync
      $error("setpt_ctrl: SYNC_STAGES must lie in 2..4");
   end

   logic [1:0] pins_s;
   logic       mode_s;
   logic       step_s;
   setpt_act_e act;

   setpt_sync #(
      .WIDTH  (2),
      .STAGES (SYNC_STAGES),
      .RST_VAL(2'b00)
   ) u_sync (
      .clk    (clk),
      .rst    (rst),
      .d_async({mode_in, step_in}),
      .q_sync (pins_s)
   );

   assign mode_s = pins_s[1];
   assign step_s = pins_s[0];

   setpt_decode u_dec (
      .clk   (clk),
      .rst   (rst),
      .mode_s(mode_s),
      .step_s(step_s),
      .act   (act),
      .run_q (run_en)
   );

   setpt_counter #(.CODE_W(CODE_W)) u_cnt (
      .clk   (clk),
      .rst   (rst),
      .act   (act),
      .code_q(code)
   );

   assert_reload_mid_R3: assert property (@(posedge clk) disable iff (rst)
      (!mode_s && step_s) |=> (code == MID_CODE && run_en));

   assert_shutdown_R4: assert property (@(posedge clk) disable iff (rst)
      (!mode_s && !step_s) |=> (!run_en && code == $past(code)));

   assert_step_low_hold_R5: assert property (@(posedge clk) disable iff (rst)
      (!step_s) |=> (code == $past(code)));

   assert_mode_high_runs_R7: assert property (@(posedge clk) disable iff (rst)
      mode_s |=> run_en);

endmodule

// File: tb/setpt_ctrl_test.sv
module setpt_ctrl_test;

   localparam int W = 6;
   localparam logic [W-1:0] MID = 6'd32;

   logic clk = 1'b0;
   logic rst;
   logic step_in, mode_in;
   logic [W-1:0] code;
   logic run_en;

   int checks = 0;
   int failures = 0;
   logic [W-1:0] exp_code;
   logic exp_run;
   logic prev_step;

   always #10 clk = ~clk;

   setpt_ctrl #(.CODE_W(W), .SYNC_STAGES(2)) uut (
      .clk(clk), .rst(rst), .step_in(step_in), .mode_in(mode_in),
      .code(code), .run_en(run_en)
   );

   function automatic logic [W-1:0] model_code(input logic [W-1:0] c,
         input logic m, input logic s, input logic sp);
      if (!m && s) return MID;
      if (m && s && !sp) return c + 1'b1;
      return c;
   endfunction

   task automatic chk(input string tag, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // Drive a pin pair on a falling edge, update the model, settle, check.
   task automatic apply(input logic m, input logic s, input string tag);
      @(negedge clk);
      mode_in = m;
      step_in = s;
      exp_code = model_code(exp_code, m, s, prev_step);
      exp_run = m | s;
      prev_step = s;
      repeat (5) @(negedge clk);
      chk({tag, " code"}, code, exp_code);
      chk({tag, " run"}, run_en, exp_run);
   endtask

   task automatic pulse(input string tag);
      apply(1'b1, 1'b1, tag);
      apply(1'b1, 1'b0, tag);
   endtask

   initial begin
      #(20 * 200000);
      failures++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      logic [W-1:0] held;
      int r;
      r = $urandom(32'h5E7B);
      rst = 1'b1;
      step_in = 1'b0;
      mode_in = 1'b1;
      exp_code = MID;
      exp_run = 1'b1;
      prev_step = 1'b0;
      repeat (3) @(negedge clk);
      chk("R1 reset code", code, 32);
      chk("R1 reset run", run_en, 1);
      rst = 1'b0;
      repeat (4) @(negedge clk);

      // R2: one step per edge
      pulse("R2 step");
      chk("R2 after one edge", code, 33);
      apply(1'b1, 1'b1, "R2 rise");
      repeat (20) @(negedge clk);
      chk("R2 held high no extra", code, 34);
      apply(1'b1, 1'b0, "R2 fall");

      // R3: reload with run kept
      apply(1'b0, 1'b1, "R3 reload");
      chk("R3 mid", code, 32);
      chk("R3 run", run_en, 1);

      // R4: shutdown retains code
      apply(1'b1, 1'b0, "R4 prep");
      pulse("R4 prep step");
      apply(1'b0, 1'b0, "R4 shutdown");
      chk("R4 run low", run_en, 0);
      chk("R4 code kept", code, 33);

      // R8: latency from the pins, from shutdown
      @(negedge clk);
      mode_in = 1'b1;
      @(posedge clk); @(posedge clk); #2;
      chk("R8 unchanged after two edges", run_en, 0);
      @(posedge clk); #2;
      chk("R8 changed on third edge", run_en, 1);
      exp_run = 1'b1;
      repeat (3) @(negedge clk);

      // R5 and R7: step low, mode toggles
      held = code;
      for (int i = 0; i < 6; i++) begin
         apply(1'b0, 1'b0, "R5 toggle low");
         apply(1'b1, 1'b0, "R7 toggle high");
         chk("R7 run with mode high", run_en, 1);
      end
      chk("R5 code unchanged", code, held);

      // R6: full lap minus one from mid-scale
      apply(1'b0, 1'b1, "R6 reload");
      apply(1'b1, 1'b0, "R6 prep");
      for (int i = 0; i < 31; i++) pulse("R6 climb");
      chk("R6 top code", code, 63);
      pulse("R6 wrap");
      chk("R6 wrap to zero", code, 0);
      for (int i = 0; i < 31; i++) pulse("R6 lap");
      chk("R6 63 steps = minus one", code, 31);

      // R9: step rise together with mode fall
      apply(1'b1, 1'b0, "R9 prep");
      pulse("R9 prep step");
      apply(1'b0, 1'b1, "R9 coincident");
      chk("R9 reload not step", code, 32);

      // Seeded random pin pairs
      for (int i = 0; i < 300; i++) begin
         r = $urandom;
         apply(r[0], r[1], "R2/R3/R4/R9 random");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule